// File: doc/BRIEF.md
# Multiplexed 4:2:2 YCbCr Input Splitter

This block sits at the pixel input of a video encoder. It receives one byte per clock of a 4:2:2 component stream in which chroma and luma bytes alternate, and it produces one luma word per luma sample together with the blue-difference and red-difference words that belong to it. The byte clock runs at twice the luma sample rate, so one luma sample is produced for every two input bytes that carry picture data.

Timing reference codes are embedded in the stream as a four-byte group: a byte of all ones, two bytes of all zeros and a flag byte. The block removes these groups from the data path and reads the field, vertical-blank and horizontal-blank flags from the flag byte. A start-of-active-video code also re-aligns the byte sorter, so the next data byte is treated as blue-difference chroma. While the blanking input is low, picture bytes are replaced with black-level values. A stray all-zeros or all-ones data byte is clamped to the nearest legal value. A two-bit control delays the luma output by zero to three luma samples relative to chroma.

Top module: `ycc_demux`

## Requirements
- R1: Data bytes are taken in the repeating order Cb, Y, Cr, Y. One output valid pulse is produced per luma sample. Each Cb/Cr pair is presented with both of the luma samples it covers and stays unchanged between those two pulses.
- R2: A group of four bytes FF, 00, 00, XY is a timing reference. None of its four bytes reaches the data outputs.
- R3: In the XY byte, bit 6 sets the field output, bit 5 sets the vertical-blank output and bit 4 sets the horizontal-blank output. Bit 4 is 1 for end of active video and 0 for start of active video. The outputs hold these values until the next timing reference.
- R4: After a start-of-active-video code (XY bit 4 = 0), the next data byte is taken as Cb, whatever the byte order was before the code.
- R5: A data byte sampled while blank_n is 0 is replaced: a luma byte becomes 16 (0x10) and a chroma byte becomes 128 (0x80).
- R6: Data byte values from 1 to 254 pass to the outputs unchanged.
- R7: A data byte of 0x00 that is not part of a timing reference is output as 0x01. A data byte of 0xFF that is not part of a timing reference is output as 0xFE.
- R8: With luma_lag = d (0 to 3), the luma presented with valid pulse k is the luma of sample k-d. Chroma is not delayed.
- R9: During and after reset, out_valid is 0, y_out is 16, cb_out and cr_out are 128, field_out is 0, and vblank_out and hblank_out are 1. The luma delay stages start at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the luma sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | DATA_W (8) | Multiplexed component byte stream |
| blank_n | input | 1 | Low: substitute black level for the byte sampled in the same cycle |
| luma_lag | input | LAG_W (2) | Luma delay in luma samples, 0 to 3 |
| y_out | output | DATA_W (8) | Luma word, after the selected delay |
| cb_out | output | DATA_W (8) | Blue-difference chroma word |
| cr_out | output | DATA_W (8) | Red-difference chroma word |
| out_valid | output | 1 | One-cycle pulse per luma sample |
| field_out | output | 1 | Field flag from the last timing reference |
| vblank_out | output | 1 | Vertical-blank flag from the last timing reference |
| hblank_out | output | 1 | Horizontal-blank flag from the last timing reference |

## Verification
The bench builds the block with its default parameters: 8-bit words and a luma delay line three samples deep. With these values the clamp limits 0x01 and 0xFE and the black levels 0x10 and 0x80 can be checked as plain byte values. Every setting of the two-bit delay control, including the deepest tap, is run on a line of distinct luma values, so each tap can be identified by what it outputs. The captured stream is compared sample by sample with a model of the byte order, the substitution rules and the delay.

// File: rtl/ycc_demux_pkg.sv
// Shared types for the 4:2:2 input splitter.
// Assumes the byte order Cb, Y, Cr, Y repeats from a start-of-video code.
package ycc_demux_pkg;

    // Position of the current data byte inside a Cb,Y,Cr,Y group
    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } byte_phase_e;

    // Timing flags taken from the flag byte of a reference code
    typedef struct packed {
        logic fld;
        logic vblk;
        logic hblk;
    } tflags_t;

endpackage

// File: rtl/trs_align.sv
// Timing-reference detector.
// Holds the last four bytes in a window so that a full FF,00,00,XY group
// is known before its first byte leaves. The oldest byte is handed on with
// a data/code mark, its own blanking bit and a start-of-video pulse.
// Assumes a reference group is never split by reset.
module trs_align
    import ycc_demux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              blank_n_in,
    output logic [DATA_W-1:0] byte_out,
    output logic              blank_n_out,
    output logic              is_data,
    output logic              sav_hit,
    output tflags_t           flags
);
    localparam int WIN   = 4;
    localparam int F_BIT = DATA_W - 2;
    localparam int V_BIT = DATA_W - 3;
    localparam int H_BIT = DATA_W - 4;
    localparam logic [DATA_W-1:0] ONES  = '1;
    localparam logic [DATA_W-1:0] ZEROS = '0;

    logic [DATA_W-1:0] win   [WIN];
    logic              win_b [WIN];
    logic              fill  [WIN];
    logic [1:0]        skip;
    logic              match;

    // Shift the byte window and its side bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) begin
                win[i]   <= ZEROS;
                win_b[i] <= 1'b1;
                fill[i]  <= 1'b0;
            end
        end else begin
            win[0]   <= byte_in;
            win_b[0] <= blank_n_in;
            fill[0]  <= 1'b1;
            for (int i = 1; i < WIN; i++) begin
                win[i]   <= win[i-1];
                win_b[i] <= win_b[i-1];
                fill[i]  <= fill[i-1];
            end
        end
    end

    // A reference starts at the oldest window byte
    always_comb begin
        match = (skip == 2'd0) && fill[WIN-1] &&
                (win[WIN-1] == ONES) && (win[2] == ZEROS) && (win[1] == ZEROS);
    end

    // Count out the three bytes that follow a detected preamble byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            skip <= 2'd0;
        else if (match)
            skip <= 2'd3;
        else if (skip != 2'd0)
            skip <= skip - 2'd1;
    end

    // Latch the timing flags from the flag byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '{fld: 1'b0, vblk: 1'b1, hblk: 1'b1};
        else if (match)
            flags <= '{fld: win[0][F_BIT], vblk: win[0][V_BIT], hblk: win[0][H_BIT]};
    end

    // Present the oldest byte with its mark
    always_comb begin
        byte_out    = win[WIN-1];
        blank_n_out = win_b[WIN-1];
        is_data     = fill[WIN-1] && !match && (skip == 2'd0);
        sav_hit     = match && !win[0][H_BIT];
    end

    // R2
    code_bytes_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !is_data);

endmodule

// File: rtl/demux_422.sv
// Byte sorter.
// Steers data bytes into Cb, Y, Cr holding registers by phase. It applies
// black-level substitution and the clamp of reserved values. A pair is
// emitted when Cr arrives, paired with the first luma; the second luma
// follows on its own byte with the same chroma.
// Assumes is_data is low for every reference-code byte.
module demux_422
    import ycc_demux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              blank_n_in,
    input  logic              is_data,
    input  logic              sav_hit,
    output logic [DATA_W-1:0] y_o,
    output logic [DATA_W-1:0] cb_o,
    output logic [DATA_W-1:0] cr_o,
    output logic              vld_o
);
    localparam logic [DATA_W-1:0] ONES    = '1;
    localparam logic [DATA_W-1:0] ZEROS   = '0;
    localparam logic [DATA_W-1:0] Y_BLACK = {4'b0001, {(DATA_W-4){1'b0}}};
    localparam logic [DATA_W-1:0] C_MID   = {1'b1, {(DATA_W-1){1'b0}}};

    byte_phase_e       phase;
    logic [DATA_W-1:0] fixed;
    logic [DATA_W-1:0] cb_hold;
    logic [DATA_W-1:0] y_hold;
    logic              is_luma;

    // Substitute black level or clamp reserved values
    always_comb begin
        is_luma = (phase == PH_Y0) || (phase == PH_Y1);
        if (!blank_n_in)
            fixed = is_luma ? Y_BLACK : C_MID;
        else if (byte_in == ZEROS)
            fixed = ZEROS + 1'b1;
        else if (byte_in == ONES)
            fixed = ONES - 1'b1;
        else
            fixed = byte_in;
    end

    // Advance the phase on data bytes, realign on start of video
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_CB;
        else if (sav_hit)
            phase <= PH_CB;
        else if (is_data)
            phase <= byte_phase_e'(phase + 2'd1);
    end

    // Hold early bytes and emit one luma sample per pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_hold <= C_MID;
            y_hold  <= Y_BLACK;
            y_o     <= Y_BLACK;
            cb_o    <= C_MID;
            cr_o    <= C_MID;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (is_data) begin
                case (phase)
                    PH_CB: cb_hold <= fixed;
                    PH_Y0: y_hold  <= fixed;
                    PH_CR: begin
                        y_o   <= y_hold;
                        cb_o  <= cb_hold;
                        cr_o  <= fixed;
                        vld_o <= 1'b1;
                    end
                    PH_Y1: begin
                        y_o   <= fixed;
                        vld_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (y_o != ZEROS) && (y_o != ONES) &&
                  (cb_o != ZEROS) && (cb_o != ONES) &&
                  (cr_o != ZEROS) && (cr_o != ONES));

    // R1
    chroma_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(cb_o) && $stable(cr_o)) |-> vld_o);

    // R1
    valid_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(vld_o)) |=> !vld_o);

endmodule

// File: rtl/luma_delay.sv
// Luma delay line.
// Shifts one stage per valid luma sample and selects the tap that gives
// the requested lag. Settings above MAX_DLY use the deepest tap.
// Assumes the lag setting is held steady while a line is in flight.
module luma_delay #(
    parameter int DATA_W  = 8,
    parameter int MAX_DLY = 3,
    parameter int LAG_W   = $clog2(MAX_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] y_in,
    input  logic              vld_in,
    input  logic [LAG_W-1:0]  lag,
    output logic [DATA_W-1:0] y_out
);
    localparam logic [DATA_W-1:0] Y_BLACK = {4'b0001, {(DATA_W-4){1'b0}}};

    logic [DATA_W-1:0] taps [MAX_DLY];

    // First stage takes the newest sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            taps[0] <= Y_BLACK;
        else if (vld_in)
            taps[0] <= y_in;
    end

    // Remaining stages follow the first
    for (genvar g = 1; g < MAX_DLY; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                taps[g] <= Y_BLACK;
            else if (vld_in)
                taps[g] <= taps[g-1];
        end
    end

    // Pick the undelayed word or a delayed tap
    always_comb begin
        int sel;
        sel = int'(lag);
        if (sel > MAX_DLY)
            sel = MAX_DLY;
        if (sel == 0)
            y_out = y_in;
        else
            y_out = taps[sel-1];
    end

endmodule

// File: rtl/ycc_demux.sv
// Top level of the 4:2:2 input splitter.
// Chains reference detection, byte sorting and the luma delay. Chroma and
// flags are not delayed; luma lags by luma_lag samples.
// Assumes one input byte per clock at twice the luma rate.
module ycc_demux
    import ycc_demux_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MAX_DLY = 3,
    parameter int LAG_W   = $clog2(MAX_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              blank_n,
    input  logic [LAG_W-1:0]  luma_lag,
    output logic [DATA_W-1:0] y_out,
    output logic [DATA_W-1:0] cb_out,
    output logic [DATA_W-1:0] cr_out,
    output logic              out_valid,
    output logic              field_out,
    output logic              vblank_out,
    output logic              hblank_out
);
    logic [DATA_W-1:0] a_byte;
    logic              a_blank_n;
    logic              a_data;
    logic              a_sav;
    tflags_t           a_flags;
    logic [DATA_W-1:0] s_y;

    trs_align #(.DATA_W(DATA_W)) u_align (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_in     (pix_in),
        .blank_n_in  (blank_n),
        .byte_out    (a_byte),
        .blank_n_out (a_blank_n),
        .is_data     (a_data),
        .sav_hit     (a_sav),
        .flags       (a_flags)
    );

    demux_422 #(.DATA_W(DATA_W)) u_sort (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (a_byte),
        .blank_n_in (a_blank_n),
        .is_data    (a_data),
        .sav_hit    (a_sav),
        .y_o        (s_y),
        .cb_o       (cb_out),
        .cr_o       (cr_out),
        .vld_o      (out_valid)
    );

    luma_delay #(.DATA_W(DATA_W), .MAX_DLY(MAX_DLY), .LAG_W(LAG_W)) u_lag (
        .clk    (clk),
        .rst_n  (rst_n),
        .y_in   (s_y),
        .vld_in (out_valid),
        .lag    (luma_lag),
        .y_out  (y_out)
    );

    // Route the timing flags to the ports
    always_comb begin
        field_out  = a_flags.fld;
        vblank_out = a_flags.vblk;
        hblank_out = a_flags.hblk;
    end

endmodule

// File: tb/ycc_demux_tb_top.sv
module ycc_demux_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCAP = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix = 8'h10;
    logic       blank_n = 1'b1;
    logic [1:0] lag = 2'd0;
    logic [7:0] y_out, cb_out, cr_out;
    logic       out_valid, field_out, vblank_out, hblank_out;

    int checks = 0;
    int errors = 0;

    ycc_demux dut_i (
        .clk(clk), .rst_n(rst_n), .pix_in(pix), .blank_n(blank_n),
        .luma_lag(lag), .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
        .out_valid(out_valid), .field_out(field_out),
        .vblank_out(vblank_out), .hblank_out(hblank_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // captured active-video samples
    logic [7:0] cap_y [NCAP];
    logic [7:0] cap_cb[NCAP];
    logic [7:0] cap_cr[NCAP];
    logic       cap_f [NCAP];
    logic       cap_v [NCAP];
    int cap_n = 0;

    always @(negedge clk) begin
        if (!rst_n) cap_n = 0;
        else if (out_valid && !hblank_out && cap_n < NCAP) begin
            cap_y[cap_n]  = y_out;
            cap_cb[cap_n] = cb_out;
            cap_cr[cap_n] = cr_out;
            cap_f[cap_n]  = field_out;
            cap_v[cap_n]  = vblank_out;
            cap_n = cap_n + 1;
        end
    end

    // expected model
    logic [7:0] ey [NCAP];
    logic [7:0] ecb[NCAP];
    logic [7:0] ecr[NCAP];
    int eg = 0;

    function automatic logic [7:0] clampv(input logic [7:0] b);
        if (b == 8'h00) return 8'h01;
        if (b == 8'hFF) return 8'hFE;
        return b;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic bn);
        @(negedge clk);
        pix = b;
        blank_n = bn;
    endtask

    task automatic do_reset(input logic [1:0] d);
        @(negedge clk);
        lag = d;
        rst_n = 1'b0;
        pix = 8'h10;
        blank_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        eg = 0;
        repeat (6) put_byte(8'h10, 1'b1);
    endtask

    task automatic send_trs(input logic [7:0] xy);
        put_byte(8'hFF, 1'b1);
        put_byte(8'h00, 1'b1);
        put_byte(8'h00, 1'b1);
        put_byte(xy, 1'b1);
    endtask

    task automatic push_group(input logic [7:0] cb, input logic [7:0] y0,
                              input logic [7:0] cr, input logic [7:0] y1,
                              input logic bn);
        put_byte(cb, bn);
        put_byte(y0, bn);
        put_byte(cr, bn);
        put_byte(y1, bn);
        ecb[eg]     = bn ? clampv(cb) : 8'h80;
        ecr[eg]     = bn ? clampv(cr) : 8'h80;
        ey[2*eg]    = bn ? clampv(y0) : 8'h10;
        ey[2*eg+1]  = bn ? clampv(y1) : 8'h10;
        eg++;
    endtask

    task automatic end_line(input logic [7:0] xy);
        send_trs(xy);
        repeat (8) put_byte(8'h10, 1'b1);
    endtask

    task automatic compare_stream(input string req);
        int d;
        d = int'(lag);
        chk({req, " sample count"}, cap_n, 2*eg);
        for (int k = 0; k < cap_n && k < 2*eg; k++) begin
            chk({req, " y"},  cap_y[k],  (k < d) ? 8'h10 : ey[k-d]);
            chk({req, " cb"}, cap_cb[k], ecb[k/2]);
            chk({req, " cr"}, cap_cr[k], ecr[k/2]);
        end
    endtask

    // R9: reset values on every output
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 valid",  out_valid, 0);
        chk("R9 y",      y_out, 8'h10);
        chk("R9 cb",     cb_out, 8'h80);
        chk("R9 cr",     cr_out, 8'h80);
        chk("R9 field",  field_out, 0);
        chk("R9 vblank", vblank_out, 1);
        chk("R9 hblank", hblank_out, 1);
    endtask

    // R1, R2, R6: ordinary line, legal extremes pass unchanged
    task automatic t_basic();
        do_reset(2'd0);
        send_trs(8'h80);
        push_group(8'h01, 8'hFE, 8'h02, 8'hFD, 1'b1);
        push_group(8'h80, 8'h10, 8'h80, 8'hEB, 1'b1);
        push_group(8'hF0, 8'h45, 8'h0F, 8'hB2, 1'b1);
        push_group(8'h7F, 8'h33, 8'h81, 8'hCC, 1'b1);
        end_line(8'h90);
        compare_stream("R1 R2 R6");
        chk("R3 hblank after end code", hblank_out, 1);
    endtask

    // R7: stray reserved values clamped
    task automatic t_clamp();
        do_reset(2'd0);
        send_trs(8'h80);
        push_group(8'h00, 8'hFF, 8'hFF, 8'h01, 1'b1);
        push_group(8'hFE, 8'h00, 8'h01, 8'h20, 1'b1);
        push_group(8'h55, 8'h66, 8'h00, 8'hFF, 1'b1);
        end_line(8'h90);
        compare_stream("R7");
    endtask

    // R5: blanking input forces black level
    task automatic t_blank();
        do_reset(2'd0);
        send_trs(8'h80);
        push_group(8'h40, 8'h50, 8'h60, 8'h70, 1'b1);
        push_group(8'hC0, 8'hD0, 8'hA0, 8'hB0, 1'b0);
        push_group(8'h21, 8'h22, 8'h23, 8'h24, 1'b1);
        end_line(8'h90);
        compare_stream("R5");
    endtask

    // R4: start code realigns the byte order after a stray byte
    task automatic t_phase();
        do_reset(2'd0);
        send_trs(8'h80);
        push_group(8'h31, 8'h41, 8'h51, 8'h61, 1'b1);
        put_byte(8'h99, 1'b1);
        send_trs(8'h80);
        push_group(8'h32, 8'h42, 8'h52, 8'h62, 1'b1);
        end_line(8'h90);
        compare_stream("R4");
    endtask

    // R8: each luma lag setting
    task automatic t_delay(input logic [1:0] d);
        do_reset(d);
        send_trs(8'h80);
        push_group(8'h81, 8'h20, 8'h82, 8'h30, 1'b1);
        push_group(8'h83, 8'h40, 8'h84, 8'h50, 1'b1);
        push_group(8'h85, 8'h60, 8'h86, 8'h70, 1'b1);
        end_line(8'h90);
        compare_stream($sformatf("R8 lag %0d", d));
    endtask

    // R3: flag bits from the reference byte
    task automatic t_flags();
        do_reset(2'd0);
        send_trs(8'hE0);
        push_group(8'h90, 8'h91, 8'h92, 8'h93, 1'b1);
        end_line(8'hF0);
        chk("R3 count", cap_n, 2);
        chk("R3 field in line", cap_f[0], 1);
        chk("R3 vblank in line", cap_v[0], 1);
        chk("R3 hblank after end", hblank_out, 1);
        chk("R3 field held", field_out, 1);
        chk("R3 vblank held", vblank_out, 1);
        send_trs(8'h90);
        repeat (3) put_byte(8'h10, 1'b1);
        chk("R3 field cleared", field_out, 0);
        chk("R3 vblank cleared", vblank_out, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_clamp();
        t_blank();
        t_phase();
        for (int d = 1; d < 4; d++) t_delay(2'(d));
        t_flags();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule